// File: doc/BRIEF.md
# Sprite Line Buffer and Pixel Serializer

This block holds the sprites chosen for one scanline and turns them into a stream of sprite pixels. It also computes the pattern memory address for every sprite row fetch. During the sprite fetch window, each of the eight slots is written once with two pattern bytes, an attribute field, an X position and a valid flag. Slots with no sprite are still written, and a slot marked invalid loads a blank pattern. During active display, a pixel strobe advances every slot. A slot counts its X position down to zero and then shifts out one pattern bit per strobe, most significant bit first.

The outputs are combinational from slot state. They give the colour index and attributes of the lowest-numbered slot that has a non-transparent pixel, and a flag that goes high when slot 0 holds the frame's first sprite and is opaque at the current pixel. A separate combinational path turns a tile index, a fine row, a flip bit and two control bits into a 14-bit pattern address. Mixing with the background is done elsewhere.

Top module: `spr_line_unit`

## Requirements
- R1: After a synchronous reset, `spr_color`, `spr_attr` and `spr_zero` are all zero until a slot is loaded.
- R2: A slot loaded with X position x outputs transparent (colour 0) until x pixel strobes have followed the load. With x = 255, the first visible bit comes after strobe 255.
- R3: After that point, the slot shows its pattern bits most significant first, one per strobe. The colour is {high-plane bit, low-plane bit}.
- R4: Once all eight bits of a slot have been shown, the slot stays transparent until its next load.
- R5: A slot loaded with `ld_valid` = 0 stays transparent whatever pattern bytes it was given.
- R6: Attribute bit 3 (horizontal flip) reverses the bit order of both pattern bytes at load time, so bit 0 is shown first.
- R7: The lowest-numbered slot with a non-zero colour drives `spr_color` and `spr_attr`. When every slot is transparent, both are zero.
- R8: `spr_zero` is 1 exactly when slot 0 was last loaded with `ld_zero` = 1 and slot 0's current colour is non-zero.
- R9: In 8-row mode (`ctl_tall` = 0), the address is {0, ctl_tbl, tile[7:0], plane, row[2:0]}.
- R10: In 16-row mode, the address is {0, tile[0], tile[7:1], row[3], plane, row[2:0]}, and `ctl_tbl` is ignored.
- R11: When `fa_vflip` = 1, the row is inverted before the address is formed: 7 - row[2:0] in 8-row mode, 15 - row in 16-row mode.
- R12: In a cycle with neither a strobe nor a load, no slot changes state, so the outputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_tall | input | 1 | 1 selects 16-row sprites |
| ctl_tbl | input | 1 | Pattern table select for 8-row sprites |
| fa_tile | input | 8 | Tile index for the address being formed |
| fa_row | input | 4 | Fine row within the sprite |
| fa_vflip | input | 1 | Vertical flip for the address being formed |
| fa_plane | input | 1 | Pattern plane (0 low, 1 high) |
| pat_addr | output | 14 | Pattern memory address |
| ld_en | input | 1 | Load strobe for one slot |
| ld_slot | input | 3 | Slot number to load |
| ld_lo | input | 8 | Low-plane pattern byte |
| ld_hi | input | 8 | High-plane pattern byte |
| ld_attr | input | 5 | Attributes: [1:0] palette, [2] priority, [3] hflip, [4] vflip |
| ld_x | input | 8 | X position |
| ld_valid | input | 1 | Slot holds a real sprite |
| ld_zero | input | 1 | Slot holds the frame's first sprite (used for slot 0) |
| pix_en | input | 1 | Pixel strobe |
| spr_color | output | 2 | Winning colour index (0 = transparent) |
| spr_attr | output | 5 | Winning slot's attributes |
| spr_zero | output | 1 | First sprite is opaque at this pixel |

## Verification
The assertions check four things on every cycle:
- A slot's remaining-bit count never goes above eight.
- A slot does not shift while its counter is still counting down.
- Slot state holds when there is neither a strobe nor a load.
- A blank load gives a transparent slot, an opaque slot 0 always reaches the output, and the zero flag only rises with an opaque output.

The exact pixel each strobe produces can only be shown by the bench's scenarios. These cover:
- when each bit appears for a given X position, including 255;
- the flipped bit order;
- how overlapping slots resolve;
- the end-of-pattern cut-off.

The bit layout of the pattern addresses is also checked only by the bench.

// File: rtl/spr_line_pkg.sv
package spr_line_pkg;

    localparam int SPR_PAT_W  = 8;
    localparam int SPR_X_W    = 8;
    localparam int SPR_ATTR_W = 5;
    localparam int SPR_ADDR_W = 14;
    localparam int SPR_LEFT_W = $clog2(SPR_PAT_W + 1);

    // attribute field positions
    localparam int ATTR_HFLIP = 3;
    localparam int ATTR_VFLIP = 4;

    typedef struct packed {
        logic [SPR_PAT_W-1:0]  lo;
        logic [SPR_PAT_W-1:0]  hi;
        logic [SPR_ATTR_W-1:0] attr;
        logic [SPR_X_W-1:0]    x;
        logic                  valid;
    } slot_load_t;

    typedef struct packed {
        logic [1:0]            color;
        logic [SPR_ATTR_W-1:0] attr;
    } spr_pix_t;

    function automatic logic [SPR_PAT_W-1:0] rev_bits(input logic [SPR_PAT_W-1:0] v);
        logic [SPR_PAT_W-1:0] r;
        for (int i = 0; i < SPR_PAT_W; i++) r[i] = v[SPR_PAT_W-1-i];
        return r;
    endfunction

endpackage

// File: rtl/spr_addr_gen.sv
module spr_addr_gen
    import spr_line_pkg::*;
(
    input  logic                  tall,
    input  logic                  tbl,
    input  logic [7:0]            tile,
    input  logic [3:0]            row,
    input  logic                  vflip,
    input  logic                  plane,
    output logic [SPR_ADDR_W-1:0] addr
);
    logic [3:0] eff_row;

    always_comb begin
        eff_row = row ^ {4{vflip}};
        if (tall)
            addr = {1'b0, tile[0], tile[7:1], eff_row[3], plane, eff_row[2:0]};
        else
            addr = {1'b0, tbl, tile, plane, eff_row[2:0]};
    end
endmodule

// File: rtl/spr_slot.sv
module spr_slot
    import spr_line_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load_fire,
    input  slot_load_t ld,
    input  logic       pix_en,
    output spr_pix_t   px
);
    logic [SPR_X_W-1:0]    cnt;
    logic [SPR_PAT_W-1:0]  sh_lo, sh_hi;
    logic [SPR_ATTR_W-1:0] attr_q;
    logic [SPR_LEFT_W-1:0] left;
    logic                  active;

    assign active = (cnt == '0) && (left != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            sh_lo  <= '0;
            sh_hi  <= '0;
            attr_q <= '0;
            left   <= '0;
        end else if (load_fire) begin
            cnt    <= ld.x;
            attr_q <= ld.attr;
            left   <= SPR_LEFT_W'(SPR_PAT_W);
            if (!ld.valid) begin
                sh_lo <= '0;
                sh_hi <= '0;
            end else if (ld.attr[ATTR_HFLIP]) begin
                sh_lo <= rev_bits(ld.lo);
                sh_hi <= rev_bits(ld.hi);
            end else begin
                sh_lo <= ld.lo;
                sh_hi <= ld.hi;
            end
        end else if (pix_en) begin
            if (cnt != '0) begin
                cnt <= cnt - SPR_X_W'(1);
            end else if (left != '0) begin
                sh_lo <= {sh_lo[SPR_PAT_W-2:0], 1'b0};
                sh_hi <= {sh_hi[SPR_PAT_W-2:0], 1'b0};
                left  <= left - SPR_LEFT_W'(1);
            end
        end
    end

    always_comb begin
        px.attr  = attr_q;
        px.color = active ? {sh_hi[SPR_PAT_W-1], sh_lo[SPR_PAT_W-1]} : 2'b00;
    end

    // R4
    left_bound_chk: assert property (@(posedge clk) disable iff (rst)
        left <= SPR_LEFT_W'(SPR_PAT_W));

    // R2
    cnt_wait_chk: assert property (@(posedge clk) disable iff (rst)
        (pix_en && !load_fire && cnt != '0) |=> (left == $past(left)));

    // R12
    hold_state_chk: assert property (@(posedge clk) disable iff (rst)
        (!pix_en && !load_fire) |=> ($stable(cnt) && $stable(left) && $stable(sh_lo) && $stable(sh_hi)));

    // R5
    blank_load_chk: assert property (@(posedge clk) disable iff (rst)
        (load_fire && !ld.valid) |=> (px.color == 2'b00));
endmodule

// File: rtl/spr_prio_sel.sv
module spr_prio_sel
    import spr_line_pkg::*;
#(
    parameter int NUM_SLOTS = 8
) (
    input  logic     clk,
    input  logic     rst,
    input  spr_pix_t px [NUM_SLOTS],
    output spr_pix_t win
);
    always_comb begin
        win = '0;
        for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
            if (px[i].color != 2'b00) win = px[i];
        end
    end

    // R7
    first_slot_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (px[0].color != 2'b00) |-> (win == px[0]));
endmodule

// File: rtl/spr_line_unit.sv
module spr_line_unit
    import spr_line_pkg::*;
#(
    parameter  int NUM_SLOTS = 8,
    localparam int SLOT_W    = $clog2(NUM_SLOTS)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  ctl_tall,
    input  logic                  ctl_tbl,
    input  logic [7:0]            fa_tile,
    input  logic [3:0]            fa_row,
    input  logic                  fa_vflip,
    input  logic                  fa_plane,
    output logic [SPR_ADDR_W-1:0] pat_addr,
    input  logic                  ld_en,
    input  logic [SLOT_W-1:0]     ld_slot,
    input  logic [SPR_PAT_W-1:0]  ld_lo,
    input  logic [SPR_PAT_W-1:0]  ld_hi,
    input  logic [SPR_ATTR_W-1:0] ld_attr,
    input  logic [SPR_X_W-1:0]    ld_x,
    input  logic                  ld_valid,
    input  logic                  ld_zero,
    input  logic                  pix_en,
    output logic [1:0]            spr_color,
    output logic [SPR_ATTR_W-1:0] spr_attr,
    output logic                  spr_zero
);
    slot_load_t ld_bus;
    spr_pix_t   slot_px [NUM_SLOTS];
    spr_pix_t   win;
    logic       zero_mark;

    assign ld_bus = '{lo: ld_lo, hi: ld_hi, attr: ld_attr, x: ld_x, valid: ld_valid};

    spr_addr_gen u_addr (
        .tall (ctl_tall),
        .tbl  (ctl_tbl),
        .tile (fa_tile),
        .row  (fa_row),
        .vflip(fa_vflip),
        .plane(fa_plane),
        .addr (pat_addr)
    );

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
        spr_slot u_slot (
            .clk      (clk),
            .rst      (rst),
            .load_fire(ld_en && (ld_slot == SLOT_W'(i))),
            .ld       (ld_bus),
            .pix_en   (pix_en),
            .px       (slot_px[i])
        );
    end

    spr_prio_sel #(.NUM_SLOTS(NUM_SLOTS)) u_prio (
        .clk(clk),
        .rst(rst),
        .px (slot_px),
        .win(win)
    );

    always_ff @(posedge clk) begin
        if (rst)
            zero_mark <= 1'b0;
        else if (ld_en && ld_slot == '0)
            zero_mark <= ld_zero;
    end

    assign spr_color = win.color;
    assign spr_attr  = win.attr;
    assign spr_zero  = zero_mark && (slot_px[0].color != 2'b00);

    // R8
    zero_opaque_chk: assert property (@(posedge clk) disable iff (rst)
        spr_zero |-> (spr_color != 2'b00));
endmodule

// File: tb/spr_line_unit_bench.sv
module spr_line_unit_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ctl_tall = 0, ctl_tbl = 0, fa_vflip = 0, fa_plane = 0;
    logic [7:0]  fa_tile = 0;
    logic [3:0]  fa_row = 0;
    logic [13:0] pat_addr;
    logic        ld_en = 0, ld_valid = 0, ld_zero = 0, pix_en = 0;
    logic [2:0]  ld_slot = 0;
    logic [7:0]  ld_lo = 0, ld_hi = 0, ld_x = 0;
    logic [4:0]  ld_attr = 0;
    logic [1:0]  spr_color;
    logic [4:0]  spr_attr;
    logic        spr_zero;

    int nchk = 0, nerr = 0;
    bit done = 0;

    always #2 clk = ~clk;

    spr_line_unit u_spr_line_unit (.*);

    // reference model state
    logic [7:0] m_lo [8], m_hi [8], m_x [8];
    logic [4:0] m_attr [8];
    logic       m_valid [8];
    logic       m_zero = 0;
    int         p = 0;

    // scoreboard queues
    logic [1:0] q_c [$];
    logic [4:0] q_a [$];
    logic       q_z [$];
    string      q_t [$];

    task automatic chk(string tag, int act, int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic logic [1:0] slot_color(int s);
        int d;
        if (!m_valid[s] || p < int'(m_x[s])) return 2'b00;
        d = p - int'(m_x[s]);
        if (d >= 8) return 2'b00;
        return {m_hi[s][7-d], m_lo[s][7-d]};
    endfunction

    task automatic push_exp(string tag);
        logic [1:0] c = 0;
        logic [4:0] a = 0;
        for (int s = 7; s >= 0; s--) begin
            if (slot_color(s) != 2'b00) begin
                c = slot_color(s);
                a = m_attr[s];
            end
        end
        q_c.push_back(c);
        q_a.push_back(a);
        q_z.push_back(m_zero && (slot_color(0) != 2'b00));
        q_t.push_back(tag);
    endtask

    // monitor
    initial forever begin
        @(negedge clk);
        while (q_c.size() > 0) begin
            string t;
            t = q_t.pop_front();
            chk({t, " colour"}, spr_color, q_c.pop_front());
            chk({t, " attr"}, spr_attr, q_a.pop_front());
            chk("R8 zero flag", spr_zero, q_z.pop_front());
        end
    end

    task automatic load(int s, logic [7:0] lo, logic [7:0] hi, logic [4:0] at,
                        logic [7:0] x, logic v, logic z);
        @(posedge clk); #1;
        ld_en = 1; ld_slot = 3'(s); ld_lo = lo; ld_hi = hi; ld_attr = at;
        ld_x = x; ld_valid = v; ld_zero = z;
        @(posedge clk); #1;
        ld_en = 0;
        m_valid[s] = v; m_x[s] = x; m_attr[s] = at;
        for (int b = 0; b < 8; b++) begin
            m_lo[s][b] = at[3] ? lo[7-b] : lo[b];
            m_hi[s][b] = at[3] ? hi[7-b] : hi[b];
        end
        if (s == 0) m_zero = z;
    endtask

    task automatic blank_all();
        for (int s = 0; s < 8; s++) load(s, 8'hFF, 8'hFF, 5'h1F, 8'd0, 1'b0, 1'b1);
    endtask

    task automatic step(string tag);
        @(posedge clk); #1; pix_en = 1;
        @(posedge clk); #1; pix_en = 0;
        p++;
        push_exp(tag);
    endtask

    task automatic idle(string tag);
        @(posedge clk); #1;
        push_exp(tag);
    endtask

    task automatic addr_chk(string tag, logic tall, logic tbl, logic [7:0] tile,
                            logic [3:0] row, logic vf, logic pl);
        int rr, e;
        ctl_tall = tall; ctl_tbl = tbl; fa_tile = tile; fa_row = row;
        fa_vflip = vf; fa_plane = pl;
        #1;
        if (tall) begin
            rr = vf ? 15 - int'(row) : int'(row);
            e = int'(tile[0]) * 4096 + int'(tile >> 1) * 32 + (rr / 8) * 16 + int'(pl) * 8 + rr % 8;
        end else begin
            rr = vf ? 7 - int'(row[2:0]) : int'(row[2:0]);
            e = int'(tbl) * 4096 + int'(tile) * 16 + int'(pl) * 8 + rr;
        end
        chk(tag, pat_addr, e);
    endtask

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nerr++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

    initial begin
        for (int s = 0; s < 8; s++) begin
            m_valid[s] = 0; m_x[s] = 0; m_lo[s] = 0; m_hi[s] = 0; m_attr[s] = 0;
        end
        repeat (3) @(posedge clk);
        #1 rst = 0;
        push_exp("R1 reset");
        idle("R1 reset");

        // line A: one sprite at x=3, invalid slots carry full patterns
        blank_all();
        load(4, 8'b1100_1010, 8'b1001_0110, 5'b00010, 8'd3, 1'b1, 1'b0);
        p = 0; push_exp("R2 R5 start");
        for (int k = 0; k < 16; k++)
            step(p < 3 ? "R2 R5 wait" : (p < 11 ? "R3 serial" : "R4 finished"));

        // line B: horizontal flip
        blank_all();
        load(1, 8'b1000_0000, 8'b0000_0011, 5'b01001, 8'd0, 1'b1, 1'b0);
        p = 0; push_exp("R6 flip");
        for (int k = 0; k < 10; k++) step("R6 flip");

        // line C: overlap, priority, zero flag, hold
        blank_all();
        load(0, 8'h0F, 8'hF0, 5'b00001, 8'd2, 1'b1, 1'b1);
        load(2, 8'hFF, 8'h00, 5'b00010, 8'd0, 1'b1, 1'b0);
        load(5, 8'hFF, 8'hFF, 5'b00011, 8'd4, 1'b1, 1'b0);
        p = 0; push_exp("R7 R8");
        for (int k = 0; k < 5; k++) step("R7 R8");
        for (int k = 0; k < 3; k++) idle("R12 hold");
        for (int k = 0; k < 9; k++) step("R7 R8");

        // line D: X at the top of its range
        blank_all();
        load(7, 8'hAA, 8'h55, 5'b00111, 8'd255, 1'b1, 1'b0);
        p = 0; push_exp("R2 x255");
        for (int k = 0; k < 265; k++) step(p < 263 ? "R2 x255" : "R4 x255");

        // pattern addresses
        addr_chk("R9 small", 0, 0, 8'h3C, 4'd5, 0, 0);
        addr_chk("R9 small", 0, 1, 8'hA7, 4'd2, 0, 1);
        addr_chk("R11 small vflip", 0, 1, 8'h12, 4'd1, 1, 0);
        addr_chk("R10 tall", 1, 0, 8'h81, 4'd11, 0, 1);
        addr_chk("R10 tall tbl ignored", 1, 1, 8'h46, 4'd3, 0, 0);
        addr_chk("R11 tall vflip", 1, 0, 8'hFF, 4'd2, 1, 1);

        repeat (4) @(posedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule